// File: doc/BRIEF.md
# Serial RAM Download Loader

This block takes control of on-chip RAM when the chip leaves reset with the boot strap asserted. It receives 8N1 characters on a serial input and writes each good character into RAM at consecutive addresses, starting from address 0. Each accepted character is echoed on an open-drain transmit output. That output only ever pulls the line low and depends on an external pull-up.

The download ends in one of two ways. The first is an idle gap of four character times after the last frame. The second is a write to the top RAM address. When it ends, the block raises a one-cycle done pulse together with the jump address at which execution should start in RAM. After that the block stays quiet until the next reset. It waits as long as needed for the first character. Baud timing is fixed by a clocks-per-bit parameter, and the CPU side is outside this block.

Top module: `serial_boot_loader`

## Requirements
- R1: The loader becomes active only if `boot_sel_i` is high at the first clock edge after `rst_ni` is released. If it is low, the loader stays inactive. Later changes of `boot_sel_i` have no effect until the next reset.
- R2: Each good frame is written to RAM in a single-cycle `ram_we_o` strobe. The frame is a low start bit, then 8 data bits with the LSB first, then a high stop bit. The first write goes to address 0, and each later write goes to the previous address plus one.
- R3: A frame whose stop bit samples low is discarded. It is not written, it does not advance the address and it is not echoed.
- R4: The loader waits without limit for the first frame. After each frame it restarts an idle timer of 4 × 10 bit times. If that timer expires, `done_o` rises exactly 4·10·CLKS_PER_BIT+1 clock cycles after the last write strobe. A gap shorter than that does not end the download.
- R5: A write to address 2^RAM_AW−1 ends the download at once, and `done_o` is high in the next cycle.
- R6: `done_o` is a single-cycle pulse, and in that cycle `jump_addr_o` equals `RAM_BASE`. At all other times `jump_addr_o` is 0.
- R7: After `done_o`, incoming frames cause no RAM write, no echo and no further done pulse until reset.
- R8: `tx_pd_o`=1 means the transmit line is pulled low. Each accepted byte is echoed as an 8N1 frame, LSB first, and `tx_pd_o` is never 1 while the loader is inactive.
- R9: While `rst_ni` is low, `done_o`, `ram_we_o`, `tx_pd_o` and `jump_addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_sel_i | input | 1 | Boot strap, sampled on the first edge after reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| tx_pd_o | output | 1 | Open-drain pull-down enable for the transmit line |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | RAM_AW | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |
| done_o | output | 1 | Download finished, one-cycle pulse |
| jump_addr_o | output | JUMP_W | Start address for execution, valid with done_o |

## Verification
The assertions check on every cycle the properties that need no timing context. Writes happen only while loading, and addresses start at 0 and step by one. A top-address write is followed by done. Done is a single pulse carrying the jump address. Nothing is written after done, and the transmit line stays released while inactive. Only the bench scenarios can show the following: byte values and their bit order, the dropping of a bad-stop frame, the exact idle-timeout cycle count, the fact that a gap shorter than the timeout does not end the download, the echoed frames, and the strap being ignored after reset.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;
  typedef enum logic [2:0] {
    LD_INIT, LD_OFF, LD_LOAD, LD_JUMP, LD_HALT
  } ld_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT
  } rx_state_e;

  localparam int unsigned CHAR_BITS = 10;  // start + 8 data + stop
endpackage

// File: rtl/boot_uart_rx.sv
module boot_uart_rx
  import boot_ld_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rxd_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       ferr_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID  = CW'(CLKS_PER_BIT / 2 - 1);

  logic s1_q, s2_q;
  rx_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (en_i && !s2_q) begin
          st_q  <= RX_START;
          cnt_q <= '0;
        end
        RX_START: if (cnt_q == MID) begin
          cnt_q <= '0;
          bit_q <= '0;
          st_q  <= s2_q ? RX_IDLE : RX_DATA;  // reject glitch
        end else cnt_q <= cnt_q + 1'b1;
        RX_DATA: if (cnt_q == LAST) begin
          cnt_q <= '0;
          sh_q  <= {s2_q, sh_q[7:1]};
          if (bit_q == 3'd7) st_q <= RX_STOP;
          else bit_q <= bit_q + 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        RX_STOP: if (cnt_q == LAST) begin
          cnt_q <= '0;
          if (s2_q) begin
            data_o  <= sh_q;
            valid_o <= 1'b1;
            st_q    <= RX_IDLE;
          end else begin
            ferr_o <= 1'b1;
            st_q   <= RX_WAIT;
          end
        end else cnt_q <= cnt_q + 1'b1;
        RX_WAIT: if (s2_q) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boot_uart_tx_od.sv
module boot_uart_tx_od #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       pull_low_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic busy_q;
  logic [CW-1:0] cnt_q;
  logic [3:0] bit_q;
  logic [9:0] sh_q;
  logic last_bit, load;

  assign last_bit = busy_q && (cnt_q == LAST) && (bit_q == 4'd9);
  assign load     = start_i && (!busy_q || last_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= {1'b1, data_i, 1'b0};
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        sh_q  <= {1'b1, sh_q[9:1]};
        if (bit_q == 4'd9) busy_q <= 1'b0;
        else bit_q <= bit_q + 1'b1;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  // only ever sinks the line; a 1 bit releases it to the pull-up
  assign pull_low_o = busy_q && !sh_q[0];
endmodule

// File: rtl/boot_idle_timer.sv
module boot_idle_timer #(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned TICKS        = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam int unsigned TW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST_C = CW'(CLKS_PER_BIT - 1);
  localparam logic [TW-1:0] LAST_T = TW'(TICKS - 1);

  logic armed_q;
  logic [CW-1:0] cc_q;
  logic [TW-1:0] tc_q;
  logic at_end;

  assign at_end   = armed_q && (cc_q == LAST_C) && (tc_q == LAST_T);
  assign expire_o = at_end && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cc_q    <= '0;
      tc_q    <= '0;
    end else if (restart_i) begin
      armed_q <= 1'b1;
      cc_q    <= '0;
      tc_q    <= '0;
    end else if (armed_q) begin
      if (cc_q == LAST_C) begin
        cc_q <= '0;
        if (tc_q == LAST_T) armed_q <= 1'b0;
        else tc_q <= tc_q + 1'b1;
      end else cc_q <= cc_q + 1'b1;
    end
  end
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader
  import boot_ld_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned RAM_AW       = 9,
  parameter int unsigned JUMP_W       = 16,
  parameter logic [JUMP_W-1:0] RAM_BASE = '0,
  parameter int unsigned IDLE_CHARS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_sel_i,
  input  logic              rxd_i,
  output logic              tx_pd_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              done_o,
  output logic [JUMP_W-1:0] jump_addr_o
);
  localparam int unsigned IDLE_TICKS = IDLE_CHARS * CHAR_BITS;
  localparam logic [RAM_AW-1:0] TOP_ADDR = '1;

  ld_state_e state_q;
  logic [RAM_AW-1:0] addr_q;
  logic loading, rx_valid, rx_ferr, timeout;
  logic [7:0] rx_data;

  assign loading = (state_q == LD_LOAD);

  boot_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_rx (
    .clk_i, .rst_ni, .en_i(loading), .rxd_i,
    .data_o(rx_data), .valid_o(rx_valid), .ferr_o(rx_ferr)
  );

  boot_idle_timer #(.CLKS_PER_BIT(CLKS_PER_BIT), .TICKS(IDLE_TICKS)) i_timer (
    .clk_i, .rst_ni,
    .restart_i(loading && (rx_valid || rx_ferr)),
    .expire_o(timeout)
  );

  assign ram_we_o    = loading && rx_valid;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = rx_data;

  boot_uart_tx_od #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_tx (
    .clk_i, .rst_ni, .start_i(ram_we_o), .data_i(rx_data), .pull_low_o(tx_pd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LD_INIT;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        LD_INIT: state_q <= boot_sel_i ? LD_LOAD : LD_OFF;
        LD_LOAD: begin
          if (ram_we_o) begin
            addr_q <= addr_q + 1'b1;
            if (addr_q == TOP_ADDR) state_q <= LD_JUMP;
          end else if (timeout) state_q <= LD_JUMP;
        end
        LD_JUMP: state_q <= LD_HALT;
        default: state_q <= state_q;  // OFF and HALT hold until reset
      endcase
    end
  end

  assign done_o      = (state_q == LD_JUMP);
  assign jump_addr_o = done_o ? RAM_BASE : '0;
endmodule

// File: rtl/serial_boot_loader_chk.sv
module serial_boot_loader_chk #(
  parameter int unsigned RAM_AW = 9,
  parameter int unsigned JUMP_W = 16,
  parameter logic [JUMP_W-1:0] RAM_BASE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              loading_i,
  input logic              off_i,
  input logic              tx_pd_i,
  input logic              ram_we_i,
  input logic [RAM_AW-1:0] ram_addr_i,
  input logic              done_i,
  input logic [JUMP_W-1:0] jump_addr_i
);
  logic have_prev_q, seen_done_q;
  logic [RAM_AW-1:0] prev_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      seen_done_q <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      if (ram_we_i) begin
        have_prev_q <= 1'b1;
        prev_addr_q <= ram_addr_i;
      end
      if (done_i) seen_done_q <= 1'b1;
    end
  end

  assert_we_only_loading_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_i |-> loading_i);
  assert_first_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_i && !have_prev_q) |-> (ram_addr_i == '0));
  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_i && have_prev_q) |-> (ram_addr_i == RAM_AW'(prev_addr_q + 1'b1)));
  assert_full_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_i && (ram_addr_i == {RAM_AW{1'b1}})) |=> done_i);
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  assert_jump_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_addr_i == (done_i ? RAM_BASE : '0));
  assert_halt_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_done_q |-> (!ram_we_i && !done_i));
  assert_tx_quiet_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |-> !tx_pd_i);
endmodule

bind serial_boot_loader serial_boot_loader_chk #(
  .RAM_AW(RAM_AW), .JUMP_W(JUMP_W), .RAM_BASE(RAM_BASE)
) i_chk (
  .clk_i, .rst_ni,
  .loading_i(state_q == boot_ld_pkg::LD_LOAD),
  .off_i(state_q == boot_ld_pkg::LD_OFF),
  .tx_pd_i(tx_pd_o), .ram_we_i(ram_we_o), .ram_addr_i(ram_addr_o),
  .done_i(done_o), .jump_addr_i(jump_addr_o)
);

// File: tb/test_serial_boot_loader.sv
module test_serial_boot_loader;
  localparam int CPB = 16;
  localparam int AW  = 4;
  localparam int JW  = 16;
  localparam logic [JW-1:0] BASE = 16'h0000;
  localparam int DEPTH = 1 << AW;
  localparam int TIMEOUT_GAP = 4 * 10 * CPB + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, boot_sel_i = 1'b0, rxd_i = 1'b1;
  logic tx_pd_o, ram_we_o, done_o;
  logic [AW-1:0] ram_addr_o;
  logic [7:0] ram_wdata_o;
  logic [JW-1:0] jump_addr_o;

  always #2 clk_i = ~clk_i;

  serial_boot_loader #(
    .CLKS_PER_BIT(CPB), .RAM_AW(AW), .JUMP_W(JW), .RAM_BASE(BASE), .IDLE_CHARS(4)
  ) i_serial_boot_loader (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  int wr_count, done_count, last_wr_cyc, done_cyc, echo_n;
  logic [JW-1:0] done_jump;
  logic [7:0] mem [DEPTH];
  logic [7:0] echo_q [64];

  always @(negedge clk_i) begin
    cyc++;
    if (ram_we_o) begin
      mem[ram_addr_o] = ram_wdata_o;
      wr_count++;
      last_wr_cyc = cyc;
    end
    if (done_o) begin
      done_count++;
      done_cyc = cyc;
      done_jump = jump_addr_o;
    end
  end

  // decode the open-drain line: level = ~tx_pd_o
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk_i);
      if (tx_pd_o) begin
        repeat (CPB / 2 - 1) @(negedge clk_i);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk_i);
          b[i] = ~tx_pd_o;
        end
        repeat (CPB) @(negedge clk_i);
        if (echo_n < 64) echo_q[echo_n] = b;
        echo_n++;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset(logic sel);
    rst_ni = 1'b0;
    boot_sel_i = sel;
    rxd_i = 1'b1;
    repeat (3) @(negedge clk_i);
    wr_count = 0; done_count = 0; echo_n = 0; last_wr_cyc = 0; done_cyc = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    chk("R9 done in reset", int'(done_o), 0);
    chk("R9 we in reset", int'(ram_we_o), 0);
    chk("R9 tx in reset", int'(tx_pd_o), 0);
    chk("R9 jump in reset", int'(jump_addr_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic idle_bits(int n);
    rxd_i = 1'b1;
    repeat (n * CPB) @(negedge clk_i);
  endtask

  task automatic send_byte(logic [7:0] b, logic stop_ok);
    rxd_i = 1'b0;
    repeat (CPB) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rxd_i = b[i];
      repeat (CPB) @(negedge clk_i);
    end
    rxd_i = stop_ok;
    repeat (CPB) @(negedge clk_i);
    rxd_i = 1'b1;
    if (!stop_ok) repeat (CPB) @(negedge clk_i);
  endtask

  task automatic t_inactive();
    do_reset(1'b0);
    send_byte(8'h5A, 1'b1);
    send_byte(8'hC3, 1'b1);
    boot_sel_i = 1'b1;  // strap after reset must be ignored
    send_byte(8'h11, 1'b1);
    idle_bits(50);
    chk("R1 no writes when strap low", wr_count, 0);
    chk("R1 no done when strap low", done_count, 0);
    chk("R8 no echo when inactive", echo_n, 0);
  endtask

  task automatic t_download();
    do_reset(1'b1);
    idle_bits(100);
    chk("R4 waits for first frame", done_count, 0);
    send_byte(8'hA5, 1'b1);
    send_byte(8'h3C, 1'b1);
    send_byte(8'h77, 1'b0);
    idle_bits(25);
    chk("R4 short gap keeps loading", done_count, 0);
    send_byte(8'h81, 1'b1);
    chk("R3 bad frame dropped, count", wr_count, 3);
    chk("R2 byte at addr 0", int'(mem[0]), 'hA5);
    chk("R2 byte at addr 1", int'(mem[1]), 'h3C);
    chk("R3 addr not advanced by bad frame", int'(mem[2]), 'h81);
    idle_bits(35);
    chk("R4 no done before timeout", done_count, 0);
    idle_bits(10);
    chk("R4 done after timeout", done_count, 1);
    chk("R4 timeout cycle count", done_cyc - last_wr_cyc, TIMEOUT_GAP);
    chk("R6 jump address", int'(done_jump), int'(BASE));
    chk("R8 echo count", echo_n, 3);
    chk("R8 echo 0", int'(echo_q[0]), 'hA5);
    chk("R8 echo 1", int'(echo_q[1]), 'h3C);
    chk("R8 echo 2", int'(echo_q[2]), 'h81);
    send_byte(8'h42, 1'b1);
    idle_bits(50);
    chk("R7 no write after done", wr_count, 3);
    chk("R6 single done pulse", done_count, 1);
    chk("R7 no echo after done", echo_n, 3);
  endtask

  task automatic t_full();
    int errs;
    do_reset(1'b1);
    boot_sel_i = 1'b0;  // R1: dropping strap after reset has no effect
    for (int i = 0; i < DEPTH; i++) send_byte(8'(i * 7 + 3), 1'b1);
    idle_bits(2);
    chk("R5 all bytes written", wr_count, DEPTH);
    chk("R5 done right after top addr", done_cyc - last_wr_cyc, 1);
    chk("R6 done count full", done_count, 1);
    chk("R6 jump address full", int'(done_jump), int'(BASE));
    errs = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'(i * 7 + 3)) errs++;
    chk("R2 full contents", errs, 0);
    idle_bits(12);
    chk("R8 echo count full", echo_n, DEPTH);
    send_byte(8'hEE, 1'b1);
    idle_bits(10);
    chk("R7 extra byte ignored", wr_count, DEPTH);
    chk("R7 no extra done", done_count, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_inactive();
    t_download();
    t_full();
    finish_run();
  end
endmodule